// File: doc/BRIEF.md
# Rotating Register File Renamer

This block is a small register file for software-pipelined loops. Its logical register space has two halves. The lower half is a fixed region, and each of its specifiers names the same physical register at all times. The upper half is a rotating region. There, a specifier is shifted by a rotating base held inside the block, and the sum wraps within that region. Each loop-closing branch (`loop_br`) lowers the base by one. A value that one iteration writes as logical Rn can therefore be read in the next iteration as logical Rn+1. The compiler uses this to express producer-to-consumer latency as a difference between register numbers, and no rename table is needed.

The block holds the physical storage. It has two combinational read ports and one write port that commits on the clock edge. The write port is a plain valid strobe, and the block accepts a write in every cycle. There is no ready signal and no back-pressure. The clear input `rrb_clr` returns the rotating base to zero.

Top module: `rrf_renamer`

## Requirements
- R1: After reset every physical register reads 0 and the rotating base is 0.
- R2: Logical specifiers 0..7 name physical registers 0..7 directly, whatever the base.
- R3: A logical specifier n in 8..15 names physical register 8 + ((n - 8 + base) mod 8).
- R4: A cycle with `loop_br` high and `rrb_clr` low lowers the base by one, and a base of 0 wraps to 7. As a result, a value written as logical n in 8..14 reads as logical n+1 after one branch, and a value written as logical 15 reads as logical 8.
- R5: A cycle with `rrb_clr` high sets the base to 0. This takes priority over `loop_br` in the same cycle.
- R6: A read or a write in the same cycle as `loop_br` or `rrb_clr` is mapped with the base value from before that cycle's update.
- R7: A write with `wr_valid` high is visible on both read ports from the next cycle. A read of the same register in the write cycle returns the old contents, because there is no bypass.
- R8: When neither `loop_br` nor `rrb_clr` is high, the base keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_br | input | 1 | Taken loop-closing branch; lowers the base |
| rrb_clr | input | 1 | Clears the rotating base to 0 |
| wr_valid | input | 1 | Write strobe, always accepted |
| wr_idx | input | 4 | Logical write specifier |
| wr_data | input | 32 | Write data |
| rd0_idx | input | 4 | Logical specifier, read port 0 |
| rd0_data | output | 32 | Read data, port 0 |
| rd1_idx | input | 4 | Logical specifier, read port 1 |
| rd1_data | output | 32 | Read data, port 1 |

## Verification
The hardest situation to reach is a write and a read in the same cycle as a branch strobe, where the old base must be used. Close behind it is the wrap of the base from 0 to 7, which the ports only show through changed data positions. The stimulus starts from reset and runs ten loop iterations, so the base passes every value and wraps. In each iteration it rewrites all sixteen logical registers with values that encode the iteration and the specifier. It then reads every specifier on both ports and fires the branch together with a write and a read. A final clear, asserted together with a branch, shows that the clear takes priority.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  // Action applied to the rotating base at the next clock edge.
  typedef enum logic [1:0] {
    BASE_HOLD  = 2'd0,
    BASE_STEP  = 2'd1,
    BASE_CLEAR = 2'd2
  } base_op_e;
endpackage

// File: rtl/rrf_base_ctr.sv
module rrf_base_ctr
  import rrf_pkg::*;
#(
  parameter int NROT = 8,
  localparam int BW = (NROT > 1) ? $clog2(NROT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  base_op_e      op,
  output logic [BW-1:0] base_q
);
  localparam logic [BW-1:0] TOP = BW'(NROT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else begin
      unique case (op)
        BASE_CLEAR: base_q <= '0;
        BASE_STEP:  base_q <= (base_q == '0) ? TOP : base_q - 1'b1;
        default:    base_q <= base_q;
      endcase
    end
  end
endmodule

// File: rtl/rrf_map.sv
module rrf_map #(
  parameter int NSTAT = 8,
  parameter int NROT  = 8,
  localparam int IW = $clog2(NSTAT + NROT),
  localparam int BW = (NROT > 1) ? $clog2(NROT) : 1
) (
  input  logic [IW-1:0] log_idx,
  input  logic [BW-1:0] base,
  output logic [IW-1:0] phys_idx
);
  logic [IW:0] off;
  logic [IW:0] sum;

  always_comb begin
    off = {1'b0, log_idx} - (IW+1)'(NSTAT);
    sum = off + (IW+1)'(base);
    if (sum >= (IW+1)'(NROT)) sum = sum - (IW+1)'(NROT);
    if (log_idx < IW'(NSTAT)) phys_idx = log_idx;
    else                      phys_idx = IW'(sum + (IW+1)'(NSTAT));
  end
endmodule

// File: rtl/rrf_store.sv
module rrf_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int NRD   = 2,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IW-1:0]           wa,
  input  logic [DW-1:0]           wd,
  input  logic [NRD-1:0][IW-1:0]  ra,
  output logic [NRD-1:0][DW-1:0]  rd
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[wa] <= wd;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd[p] = cells[ra[p]];
  end
endmodule

// File: rtl/rrf_renamer.sv
module rrf_renamer
  import rrf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NSTAT = 8,
  parameter int NROT  = 8,
  localparam int DEPTH = NSTAT + NROT,
  localparam int IW    = $clog2(DEPTH),
  localparam int BW    = (NROT > 1) ? $clog2(NROT) : 1,
  localparam int NRD   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loop_br,
  input  logic          rrb_clr,
  input  logic          wr_valid,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd0_idx,
  output logic [DW-1:0] rd0_data,
  input  logic [IW-1:0] rd1_idx,
  output logic [DW-1:0] rd1_data
);
  logic [BW-1:0]          base_q;
  base_op_e               base_op;
  logic [IW-1:0]          wr_phys;
  logic [NRD-1:0][IW-1:0] rd_log;
  logic [NRD-1:0][IW-1:0] rd_phys;
  logic [NRD-1:0][DW-1:0] rd_val;

  // Clear wins over step.
  always_comb begin
    if (rrb_clr)      base_op = BASE_CLEAR;
    else if (loop_br) base_op = BASE_STEP;
    else              base_op = BASE_HOLD;
  end

  rrf_base_ctr #(.NROT(NROT)) u_base (
    .clk(clk), .rst_n(rst_n), .op(base_op), .base_q(base_q)
  );

  rrf_map #(.NSTAT(NSTAT), .NROT(NROT)) u_wmap (
    .log_idx(wr_idx), .base(base_q), .phys_idx(wr_phys)
  );

  assign rd_log[0] = rd0_idx;
  assign rd_log[1] = rd1_idx;

  for (genvar p = 0; p < NRD; p++) begin : g_rmap
    rrf_map #(.NSTAT(NSTAT), .NROT(NROT)) u_rmap (
      .log_idx(rd_log[p]), .base(base_q), .phys_idx(rd_phys[p])
    );
  end

  rrf_store #(.DEPTH(DEPTH), .DW(DW), .NRD(NRD)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_valid), .wa(wr_phys), .wd(wr_data),
    .ra(rd_phys), .rd(rd_val)
  );

  assign rd0_data = rd_val[0];
  assign rd1_data = rd_val[1];
endmodule

// File: rtl/rrf_renamer_chk.sv
module rrf_renamer_chk #(
  parameter int DW = 32,
  parameter int NSTAT = 8,
  parameter int NROT = 8,
  parameter int IW = 4,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          loop_br,
  input logic          rrb_clr,
  input logic [BW-1:0] base_q,
  input logic          wr_valid,
  input logic [IW-1:0] wr_phys,
  input logic [DW-1:0] wr_data,
  input logic [IW-1:0] rd0_idx,
  input logic [IW-1:0] rd0_phys,
  input logic [DW-1:0] rd0_data
);
  a_r4_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_br && !rrb_clr) |=> base_q == (($past(base_q) == '0) ?
                                          BW'(NROT - 1) : $past(base_q) - 1'b1));

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rrb_clr |=> base_q == '0);

  a_r8_base_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_br && !rrb_clr) |=> $stable(base_q));

  a_r2_static_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_idx < IW'(NSTAT)) |-> rd0_phys == rd0_idx);

  a_r3_rot_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_idx >= IW'(NSTAT)) |-> rd0_phys >= IW'(NSTAT));

  a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> (rd0_phys != $past(wr_phys) || rd0_data == $past(wr_data)));
endmodule

bind rrf_renamer rrf_renamer_chk #(
  .DW(DW), .NSTAT(NSTAT), .NROT(NROT), .IW(IW), .BW(BW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .loop_br(loop_br), .rrb_clr(rrb_clr),
  .base_q(base_q), .wr_valid(wr_valid), .wr_phys(wr_phys),
  .wr_data(wr_data), .rd0_idx(rd0_idx), .rd0_phys(rd_phys[0]),
  .rd0_data(rd0_data)
);

// File: tb/rrf_renamer_tb.sv
`timescale 1ns/1ps
module rrf_renamer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loop_br = 1'b0, rrb_clr = 1'b0, wr_valid = 1'b0;
  logic [3:0]  wr_idx = '0, rd0_idx = '0, rd1_idx = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd0_data, rd1_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] m [16];
  int rrb = 0;

  always #2.5 clk = ~clk;

  rrf_renamer dut_i (
    .clk(clk), .rst_n(rst_n), .loop_br(loop_br), .rrb_clr(rrb_clr),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_data(rd1_data)
  );

  function automatic int phys(int idx, int base);
    if (idx < 8) return idx;
    return 8 + ((idx - 8 + base) % 8);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_pair(int a, int b, string req);
    @(negedge clk);
    rd0_idx = 4'(a);
    rd1_idx = 4'(b);
    #1;
    check(req, rd0_data, m[phys(a, rrb)]);
    check(req, rd1_data, m[phys(b, rrb)]);
  endtask

  // One cycle with optional write, branch and clear; the written
  // register is read in the same cycle (no bypass, old base).
  task automatic cycle(bit wv, int idx, logic [31:0] d, bit br, bit clr, string req);
    int p;
    @(negedge clk);
    wr_valid = wv; wr_idx = 4'(idx); wr_data = d;
    loop_br = br; rrb_clr = clr;
    rd0_idx = 4'(idx); rd1_idx = 4'(idx);
    #1;
    p = phys(idx, rrb);
    check(req, rd0_data, m[p]);
    @(posedge clk);
    if (wv) m[p] = d;
    if (clr) rrb = 0;
    else if (br) rrb = (rrb == 0) ? 7 : rrb - 1;
    #1;
    wr_valid = 0; loop_br = 0; rrb_clr = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 16; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: all zero after reset, base zero
    for (int i = 0; i < 16; i++) read_pair(i, 15 - i, "R1");

    for (int it = 0; it < 10; it++) begin
      // R7: write every logical register, same-cycle read sees old value
      for (int i = 0; i < 16; i++)
        cycle(1'b1, i, {8'(it), 8'hA5, 8'(i), 8'(rrb)}, 1'b0, 1'b0, "R7");
      // R2/R3: read back through both ports at current base
      for (int i = 0; i < 16; i++) read_pair(i, 15 - i, i < 8 ? "R2" : "R3");
      // R8: an idle cycle keeps the base
      cycle(1'b0, 0, '0, 1'b0, 1'b0, "R8");
      for (int i = 8; i < 16; i++) read_pair(i, i, "R8");
      // R6: write and read during the branch use the old base
      v = {8'(it), 8'h66, 8'd9, 8'(rrb)};
      cycle(1'b1, 9, v, 1'b1, 1'b0, "R6");
      // R4: value from logical n now reads as n+1 (15 wraps to 8)
      read_pair(10, 10, "R4");
      check("R4", rd0_data, v);
      for (int i = 8; i < 15; i++) read_pair(i + 1, i + 1, "R4");
      read_pair(8, 8, "R4");
      check("R4", rd1_data, {8'(it), 8'hA5, 8'd15, 8'((rrb + 1) % 8)});
    end

    // R5: clear wins over branch; accesses in that cycle use the old base
    cycle(1'b1, 12, 32'hC1EA_0012, 1'b1, 1'b1, "R5");
    for (int i = 8; i < 16; i++) read_pair(i, 23 - i, "R5");
    // R2: static region unaffected by base change
    for (int i = 0; i < 8; i++) read_pair(i, 7 - i, "R2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule